// File: doc/BRIEF.md
# Dual 32-bit count-up timer pair

This peripheral holds two independent count-up timers, a low half and a high half, behind one small register window. Each half owns a counter and a period register. When a running counter reaches its period, the half raises a one-cycle interrupt and restarts from zero. In one-shot mode it also drops its own enable mode back to disabled.

Software sets each half's enable mode through two 2-bit fields of a shared control register. A global register releases each half from reset and selects the timer mode. Only the dual unchained 32-bit mode makes the halves count. The other mode codes are stored and read back but leave both counters stopped.

Software can load a counter directly at any time, for example to clear it before starting a new period. A period of all ones makes a half run through the whole counter range and wrap.

Top module: `pair_tick_timer`

## Requirements
- R1: A cycle with `rst` high clears every counter, period, enable-mode field, reset-release bit and the timer-mode field. It also drives `irq_lo`, `irq_hi` and `rdata` low from the next cycle on.
- R2: A read with `rd_en` high returns its data on `rdata` in the following cycle. The byte offsets are:
  - 0x00: the constant `ID_VALUE`
  - 0x10: low counter
  - 0x14: high counter
  - 0x18: low period
  - 0x1C: high period
  - 0x20: control register. The low enable mode is at bits 7:6 and the high enable mode at bits 23:22. All other bits read 0.
  - 0x24: global register. The low release bit is at bit 0, the high release bit at bit 1, and the timer mode at bits 3:2. All other bits read 0.
  - 0x28 and every other offset read 0.
  - Counters and periods read zero-extended.
- R3: A half counts up by one per cycle only when all three hold: its release bit is 1, the timer mode is 1 (dual unchained), and its enable mode is nonzero. Modes 0, 2 and 3 leave both counters stopped.
- R4: A running half whose counter equals its period sets its interrupt high for exactly the next cycle. Its counter is 0 in that same cycle.
- R5: Enable mode 1 is one-shot: the period match also clears that half's enable-mode field to 0. Modes 2 and 3 keep running periodically.
- R6: While a half's release bit is 0, its counter is held at zero and writes to that counter have no effect.
- R7: A write to a counter register of a released half loads the written value. It takes priority over the increment and the period match in that same cycle.
- R8: A period of all ones lets a counter run through its maximum value, wrap to zero and raise one interrupt per full turn.
- R9: The two halves are independent: releasing, enabling, loading or matching one half never changes the other half's counter, field or interrupt.
- R10: A control-register write in the same cycle as a one-shot match stores the written enable mode instead of clearing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Byte offset of the register accessed |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, registered, valid the cycle after `rd_en` |
| irq_lo | output | 1 | One-cycle interrupt of the low half |
| irq_hi | output | 1 | One-cycle interrupt of the high half |

## Verification
The bench builds the block with an 8-bit counter width (`CW = 8`) and keeps the 32-bit register data path. This brings the all-ones period, the wrap past the maximum count and repeated periodic matches within a few hundred cycles. The field positions and offsets stay as they are in the full-width build. A behavioural model, stepped alongside the design, checks both interrupts every cycle and every read result. Directed steps also land a control write on the exact cycle of a one-shot match.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    EN_OFF  = 2'd0,
    EN_ONCE = 2'd1,
    EN_CONT = 2'd2,
    EN_ALT  = 2'd3
  } en_mode_t;

  typedef enum logic [1:0] {
    TM_GP64  = 2'd0,
    TM_DUAL  = 2'd1,
    TM_WD64  = 2'd2,
    TM_CHAIN = 2'd3
  } tmode_t;

  localparam logic [7:0] OFF_ID     = 8'h00;
  localparam logic [7:0] OFF_CNT_LO = 8'h10;
  localparam logic [7:0] OFF_CNT_HI = 8'h14;
  localparam logic [7:0] OFF_PRD_LO = 8'h18;
  localparam logic [7:0] OFF_PRD_HI = 8'h1C;
  localparam logic [7:0] OFF_CTRL   = 8'h20;
  localparam logic [7:0] OFF_GLOB   = 8'h24;

  localparam int EN_W = 2;

endpackage

// File: rtl/tmr_half.sv
module tmr_half
  import tmr_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rel,
  input  logic            tm_dual,
  input  logic            cnt_we,
  input  logic            prd_we,
  input  logic            en_we,
  input  logic [CW-1:0]   wd,
  input  logic [EN_W-1:0] en_wd,
  output logic [CW-1:0]   cnt_q,
  output logic [CW-1:0]   prd_q,
  output logic [EN_W-1:0] en_q,
  output logic            irq_q
);

  logic run;
  logic hit;

  // counting gate and period match; a counter load suppresses the match
  always_comb begin
    run = rel && tm_dual && (en_q != EN_OFF);
    hit = run && (cnt_q == prd_q) && !cnt_we;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prd_q <= '0;
    end else if (prd_we) begin
      prd_q <= wd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !rel) begin
      cnt_q <= '0;
    end else if (cnt_we) begin
      cnt_q <= wd;
    end else if (hit) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= EN_OFF;
    end else if (en_we) begin
      en_q <= en_wd;
    end else if (hit && (en_q == EN_ONCE)) begin
      en_q <= EN_OFF;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= hit;
    end
  end

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int          AW       = 6,
  parameter int          DW       = 32,
  parameter int          CW       = 32,
  parameter logic [31:0] ID_VALUE = 32'h7173_0001,
  parameter int          LO_POS   = 6,
  parameter int          HI_POS   = 22
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [CW-1:0]   cnt_q [2],
  input  logic [CW-1:0]   prd_q [2],
  input  logic [EN_W-1:0] en_q  [2],
  output logic [1:0]      cnt_we,
  output logic [1:0]      prd_we,
  output logic            en_we,
  output logic [EN_W-1:0] en_wd [2],
  output logic [1:0]      rel,
  output logic [1:0]      tmode,
  output logic [DW-1:0]   rdata
);

  localparam logic [AW-1:0] A_ID     = AW'(OFF_ID);
  localparam logic [AW-1:0] A_CNT_LO = AW'(OFF_CNT_LO);
  localparam logic [AW-1:0] A_CNT_HI = AW'(OFF_CNT_HI);
  localparam logic [AW-1:0] A_PRD_LO = AW'(OFF_PRD_LO);
  localparam logic [AW-1:0] A_PRD_HI = AW'(OFF_PRD_HI);
  localparam logic [AW-1:0] A_CTRL   = AW'(OFF_CTRL);
  localparam logic [AW-1:0] A_GLOB   = AW'(OFF_GLOB);

  // write strobes
  always_comb begin
    cnt_we[0] = wr_en && (addr == A_CNT_LO);
    cnt_we[1] = wr_en && (addr == A_CNT_HI);
    prd_we[0] = wr_en && (addr == A_PRD_LO);
    prd_we[1] = wr_en && (addr == A_PRD_HI);
    en_we     = wr_en && (addr == A_CTRL);
    en_wd[0]  = wdata[LO_POS +: EN_W];
    en_wd[1]  = wdata[HI_POS +: EN_W];
  end

  // global register: release bits and timer mode
  always_ff @(posedge clk) begin
    if (rst) begin
      rel   <= '0;
      tmode <= TM_GP64;
    end else if (wr_en && (addr == A_GLOB)) begin
      rel   <= wdata[1:0];
      tmode <= wdata[3:2];
    end
  end

  // read mux
  logic [DW-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    unique case (addr)
      A_ID:     rd_mux = DW'(ID_VALUE);
      A_CNT_LO: rd_mux = DW'(cnt_q[0]);
      A_CNT_HI: rd_mux = DW'(cnt_q[1]);
      A_PRD_LO: rd_mux = DW'(prd_q[0]);
      A_PRD_HI: rd_mux = DW'(prd_q[1]);
      A_CTRL: begin
        rd_mux[LO_POS +: EN_W] = en_q[0];
        rd_mux[HI_POS +: EN_W] = en_q[1];
      end
      A_GLOB: begin
        rd_mux[1:0] = rel;
        rd_mux[3:2] = tmode;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/pair_tick_timer.sv
module pair_tick_timer
  import tmr_pkg::*;
#(
  parameter int          AW       = 6,
  parameter int          DW       = 32,
  parameter int          CW       = 32,
  parameter logic [31:0] ID_VALUE = 32'h7173_0001,
  parameter int          LO_POS   = 6,
  parameter int          HI_POS   = 22
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq_lo,
  output logic          irq_hi
);

  localparam int NH = 2;

  logic [CW-1:0]   cnt_q [NH];
  logic [CW-1:0]   prd_q [NH];
  logic [EN_W-1:0] en_q  [NH];
  logic [EN_W-1:0] en_wd [NH];
  logic [NH-1:0]   cnt_we;
  logic [NH-1:0]   prd_we;
  logic [NH-1:0]   irq_v;
  logic [NH-1:0]   rel;
  logic [1:0]      tmode;
  logic            en_we;
  logic            tm_dual;

  assign tm_dual = (tmode == TM_DUAL);

  tmr_regs #(
    .AW(AW), .DW(DW), .CW(CW), .ID_VALUE(ID_VALUE),
    .LO_POS(LO_POS), .HI_POS(HI_POS)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .wdata  (wdata),
    .cnt_q  (cnt_q),
    .prd_q  (prd_q),
    .en_q   (en_q),
    .cnt_we (cnt_we),
    .prd_we (prd_we),
    .en_we  (en_we),
    .en_wd  (en_wd),
    .rel    (rel),
    .tmode  (tmode),
    .rdata  (rdata)
  );

  for (genvar h = 0; h < NH; h++) begin : g_half
    tmr_half #(.CW(CW)) u_half (
      .clk     (clk),
      .rst     (rst),
      .rel     (rel[h]),
      .tm_dual (tm_dual),
      .cnt_we  (cnt_we[h]),
      .prd_we  (prd_we[h]),
      .en_we   (en_we),
      .wd      (wdata[CW-1:0]),
      .en_wd   (en_wd[h]),
      .cnt_q   (cnt_q[h]),
      .prd_q   (prd_q[h]),
      .en_q    (en_q[h]),
      .irq_q   (irq_v[h])
    );
  end

  assign irq_lo = irq_v[0];
  assign irq_hi = irq_v[1];

endmodule

// File: rtl/timer_pair_chk.sv
module timer_pair_chk
  import tmr_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 32,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          irq_lo,
  input logic          irq_hi,
  input logic [1:0]    rel,
  input logic [1:0]    tmode,
  input logic [CW-1:0] cnt_lo,
  input logic [CW-1:0] cnt_hi,
  input logic [1:0]    en_lo
);

  logic wr_cnt_lo, wr_ctrl;
  assign wr_cnt_lo = wr_en && (addr == AW'(OFF_CNT_LO));
  assign wr_ctrl   = wr_en && (addr == AW'(OFF_CTRL));

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!irq_lo && !irq_hi && rdata == '0));

  a_r4_irq_zero_lo: assert property (@(posedge clk) disable iff (rst)
    irq_lo |-> cnt_lo == '0);

  a_r4_irq_zero_hi: assert property (@(posedge clk) disable iff (rst)
    irq_hi |-> cnt_hi == '0);

  a_r6_hold_lo: assert property (@(posedge clk) disable iff (rst)
    !rel[0] |=> cnt_lo == '0);

  a_r6_hold_hi: assert property (@(posedge clk) disable iff (rst)
    !rel[1] |=> cnt_hi == '0);

  a_r3_idle_lo: assert property (@(posedge clk) disable iff (rst)
    (rel[0] && tmode != 2'd1 && !wr_cnt_lo) |=> $stable(cnt_lo));

  a_r5_once_lo: assert property (@(posedge clk) disable iff (rst)
    (irq_lo && $past(en_lo) == 2'd1 && !$past(wr_ctrl)) |-> en_lo == 2'd0);

  a_r7_load_lo: assert property (@(posedge clk) disable iff (rst)
    (wr_cnt_lo && rel[0]) |=> (cnt_lo == $past(wdata[CW-1:0]) && !irq_lo));

endmodule

bind pair_tick_timer timer_pair_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .wr_en  (wr_en),
  .addr   (addr),
  .wdata  (wdata),
  .rdata  (rdata),
  .irq_lo (irq_lo),
  .irq_hi (irq_hi),
  .rel    (rel),
  .tmode  (tmode),
  .cnt_lo (cnt_q[0]),
  .cnt_hi (cnt_q[1]),
  .en_lo  (en_q[0])
);

// File: tb/sim_pair_tick_timer.sv
`timescale 1ns/1ps
module sim_pair_tick_timer;

  localparam int          AW  = 6;
  localparam int          DW  = 32;
  localparam int          CW  = 8;
  localparam logic [31:0] IDV = 32'h7173_0001;
  localparam int          MSK = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq_lo, irq_hi;

  always #4 clk = ~clk;

  pair_tick_timer #(.AW(AW), .DW(DW), .CW(CW), .ID_VALUE(IDV)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic check(input string tag, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  mc[2], mp[2], me[2];
  bit  mrel[2];
  int  mtm;
  bit  mirq[2];
  longint mrd;
  bit  rd_pend;

  always @(posedge clk) begin
    int  nc[2], ne[2];
    bit  hit[2];
    longint rv;
    if (rst) begin
      for (int h = 0; h < 2; h++) begin
        mc[h] = 0; mp[h] = 0; me[h] = 0; mrel[h] = 0; mirq[h] = 0;
      end
      mtm = 0; mrd = 0; rd_pend = 0;
    end else begin
      for (int h = 0; h < 2; h++) begin
        bit run, cw;
        run = mrel[h] && (mtm == 1) && (me[h] != 0);
        cw  = wr_en && (addr == AW'(16 + 4*h));
        hit[h] = run && (mc[h] == mp[h]) && !cw;
        if (!mrel[h])    nc[h] = 0;
        else if (cw)     nc[h] = int'(wdata) & MSK;
        else if (hit[h]) nc[h] = 0;
        else if (run)    nc[h] = (mc[h] + 1) & MSK;
        else             nc[h] = mc[h];
        if (wr_en && addr == AW'(32)) ne[h] = int'(wdata >> (h ? 22 : 6)) & 3;
        else if (hit[h] && me[h] == 1) ne[h] = 0;
        else ne[h] = me[h];
      end
      case (int'(addr))
        0:  rv = IDV;
        16: rv = mc[0];
        20: rv = mc[1];
        24: rv = mp[0];
        28: rv = mp[1];
        32: rv = (longint'(me[0]) << 6) | (longint'(me[1]) << 22);
        36: rv = mrel[0] | (mrel[1] << 1) | (mtm << 2);
        default: rv = 0;
      endcase
      rd_pend = rd_en;
      if (rd_en) mrd = rv;
      for (int h = 0; h < 2; h++) begin
        mc[h] = nc[h]; me[h] = ne[h]; mirq[h] = hit[h];
        if (wr_en && addr == AW'(24 + 4*h)) mp[h] = int'(wdata) & MSK;
      end
      if (wr_en && addr == AW'(36)) begin
        mrel[0] = wdata[0]; mrel[1] = wdata[1]; mtm = int'(wdata[3:2]);
      end
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R4 irq_lo model", irq_lo, mirq[0]);
      check("R9 irq_hi model", irq_hi, mirq[1]);
      if (rd_pend) check("R2 rdata model", rdata, mrd);
    end
  end

  // interrupt pulse counters, sampled just after each edge
  int n_lo = 0, n_hi = 0;
  always @(posedge clk) begin
    #1;
    if (irq_lo) n_lo++;
    if (irq_hi) n_hi++;
  end

  // ---------------- bus tasks (called at a falling edge) ----------------
  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input longint exp, input string tag);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    check(tag, rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 irq_lo after reset", irq_lo, 0);
    check("R1 irq_hi after reset", irq_hi, 0);
    check("R1 rdata after reset", rdata, 0);
    rd(16, 0, "R1 low counter");
    rd(24, 0, "R1 low period");
    rd(32, 0, "R1 control");
    rd(36, 0, "R1 global");

    rd(0, IDV, "R2 id");
    rd(40, 0, "R2 offset 0x28");
    wr(24, 32'd5);
    rd(24, 5, "R2 low period");
    wr(28, 32'd3);
    rd(28, 3, "R2 high period");
    wr(32, ~32'h00C0_00C0 | 32'h0040_0080);
    rd(32, 32'h0040_0080, "R2 control fields");

    wr(16, 32'd9);
    rd(16, 0, "R6 write ignored in reset");

    wr(36, 32'h3);
    idle(5);
    rd(16, 0, "R3 mode 0 stops count");
    rd(36, 32'h3, "R2 global readback");
    wr(32, 32'h0);
    wr(36, 32'h7);
    idle(4);
    rd(16, 0, "R3 enable 0 stops count");

    n_lo = 0; n_hi = 0;
    wr(32, 32'h0040_0080);
    idle(20);
    check("R5 one-shot single pulse", n_hi, 1);
    rd(32, 32'h0000_0080, "R5 one-shot field cleared");
    check("R4 periodic pulses", n_lo >= 3, 1);

    wr(16, 32'd3);
    rd(16, 3, "R7 load beats increment");

    wr(24, 32'hFFFF_FFFF);
    wr(16, 32'hFD);
    n_lo = 0;
    idle(4);
    check("R8 wrap pulse", n_lo, 1);
    idle(300);
    check("R8 one pulse per turn", n_lo, 2);

    wr(36, 32'h5);
    rd(20, 0, "R9 high held while low runs");
    rd(32, 32'h0000_0080, "R9 high field unchanged");

    wr(24, 32'd2);
    wr(32, 32'h0000_0040);
    wr(16, 32'd0);
    idle(2);
    wr(32, 32'h0000_0080);
    rd(32, 32'h0000_0080, "R10 write wins over one-shot clear");
    idle(10);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule